// File: doc/BRIEF.md
# Command-Latching Transmit FIFO Push Port

This block is the write side of a serial-master transmit queue. Every queue entry is one word made of a command half, which sits in the upper bits, and a transmit-data half, which sits in the lower bits. Bus writes arrive with byte enables, so a single write can cover one byte, two bytes or the whole word. The port keeps a shadow copy of the latest command half. When a write covers only data bytes, the port joins those bytes to the shadow command and pushes the complete entry. A write that covers only command bytes changes the shadow and pushes nothing. Because of this, a DMA engine can stream bare bytes or halfwords from a packed buffer while one command setting stays in force.

The queue behind the port is a small synchronous FIFO. Its head is visible on `pop_data`, and it has full and empty flags and a pop strobe. A push that finds the queue full, with no pop in the same cycle, is dropped and sets a sticky overflow flag. Software clears that flag through a second register address.

Top module: `txpush_port`

## Requirements
- R1: After reset the queue is empty, not full, the overflow flag is 0 and the shadow command is all zeros, so the first data-only write pushes an entry with command half 0x0000.
- R2: A push-register write with every byte enable set pushes the full write word as one entry and also loads its upper half into the shadow command.
- R3: A push-register write whose enables cover only data bytes (enable bits 1:0) pushes one entry. Its upper half is the shadow command, never zero and never the write word's upper bits.
- R4: In a pushed data half, each data byte whose enable is clear is zero. A write with only enable bit 0 set gives data bits 15:8 = 0x00, and a write with only enable bit 1 set gives data bits 7:0 = 0x00.
- R5: A push-register write whose enables cover only command bytes (enable bits 3:2) pushes nothing. It updates only the enabled bytes of the shadow command, and later data-only writes carry the new command.
- R6: A push-register write whose enables cover bytes in both halves but not all four bytes first merges its enabled command bytes into the shadow and then, in the same cycle, pushes {updated shadow, data half}.
- R7: Entries leave in the order they were pushed, and `pop_data` always shows the oldest entry. A push and a pop in the same cycle both take effect, including when the queue is full.
- R8: `fifo_full` is 1 exactly when DEPTH (default 4) entries are held, and `fifo_empty` is 1 exactly when none are held. A pop while the queue is empty has no effect.
- R9: A push while the queue is full and no pop is given is dropped and sets `overflow`. The flag stays set until a status write (`bus_addr`=1) with enable bit 0 set and data bit 0 = 1. A status write with data bit 0 = 0 leaves it set.
- R10: A status-register write pushes nothing, and a push-register write with all enables clear pushes nothing and leaves the shadow unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 1 | 0 = push register, 1 = status register |
| bus_be | input | 4 | Byte enables; bits 3:2 command half, bits 1:0 data half |
| bus_wdata | input | 32 | Write data |
| pop | input | 1 | Remove the head entry |
| pop_data | output | 32 | Head entry, valid while not empty |
| fifo_empty | output | 1 | Queue holds no entries |
| fifo_full | output | 1 | Queue holds DEPTH entries |
| overflow | output | 1 | Sticky dropped-push flag |

## Verification
The bench follows the shadow command across mixed write widths. A design that cleared the upper half on narrow writes, or took the upper half from the write word, would show the wrong command on popped entries. It also sends command-only writes of a single byte, and a design that pushed on them or overwrote the whole shadow would add entries or corrupt the command. At a full queue it drives a push with a simultaneous pop and a push without a pop. A design that got these wrong would lose data, reorder entries or leave `overflow` clear. It also sends status writes with data bit 0 at both values: a clear that ignored the bit, or a status write that leaked into the queue, would change the flag or the entry count.

// File: rtl/txpush_pkg.sv
package txpush_pkg;
   typedef enum logic [0:0] {
      SEL_PUSH = 1'b0,
      SEL_STAT = 1'b1
   } reg_sel_e;

   localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/txpush_merge.sv
module txpush_merge #(
   parameter int unsigned CMD_W = 16,
   parameter int unsigned DAT_W = 16,
   localparam int unsigned DW = CMD_W + DAT_W,
   localparam int unsigned NB = DW / txpush_pkg::BYTE_W,
   localparam int unsigned DB = DAT_W / txpush_pkg::BYTE_W,
   localparam int unsigned CB = CMD_W / txpush_pkg::BYTE_W
) (
   input  logic [NB-1:0]    be,
   input  logic [DW-1:0]    wdata,
   input  logic [CMD_W-1:0] shadow,
   output logic [CMD_W-1:0] next_cmd,
   output logic [DW-1:0]    entry,
   output logic             data_hit
);
   localparam int unsigned BW = txpush_pkg::BYTE_W;

   logic [DAT_W-1:0] data_half;

   for (genvar i = 0; i < DB; i++) begin : g_dat
      assign data_half[BW*i +: BW] = be[i] ? wdata[BW*i +: BW] : '0;
   end

   for (genvar j = 0; j < CB; j++) begin : g_cmd
      assign next_cmd[BW*j +: BW] = be[DB+j] ? wdata[DAT_W + BW*j +: BW]
                                             : shadow[BW*j +: BW];
   end

   assign data_hit = |be[DB-1:0];
   assign entry    = {next_cmd, data_half};
endmodule

// File: rtl/txpush_fifo.sv
module txpush_fifo #(
   parameter int unsigned W     = 32,
   parameter int unsigned DEPTH = 4,
   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CW = $clog2(DEPTH + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic         pop,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CW-1:0] count;
   logic          push_ok, pop_ok;

   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign pop_ok  = pop && !empty;
   assign push_ok = push && (!full || pop);

   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_nxt = wr_ptr + AW'(1);
      assign rd_nxt = rd_ptr + AW'(1);
   end else begin : g_wrap
      assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
      assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_nxt;
         if (pop_ok)  rd_ptr <= rd_nxt;
         if (push_ok && !pop_ok)      count <= count + CW'(1);
         else if (pop_ok && !push_ok) count <= count - CW'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= din;
   end

   assign dout = mem[rd_ptr];
endmodule

// File: rtl/txpush_port.sv
module txpush_port #(
   parameter int unsigned CMD_W = 16,
   parameter int unsigned DAT_W = 16,
   parameter int unsigned DEPTH = 4,
   localparam int unsigned DW = CMD_W + DAT_W,
   localparam int unsigned NB = DW / 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_wr,
   input  logic          bus_addr,
   input  logic [NB-1:0] bus_be,
   input  logic [DW-1:0] bus_wdata,
   input  logic          pop,
   output logic [DW-1:0] pop_data,
   output logic          fifo_empty,
   output logic          fifo_full,
   output logic          overflow
);
   import txpush_pkg::*;

   if (CMD_W % BYTE_W != 0 || CMD_W == 0) begin : g_bad_cmd
      $error("CMD_W must be a nonzero multiple of 8");
   end
   if (DAT_W % BYTE_W != 0 || DAT_W == 0) begin : g_bad_dat
      $error("DAT_W must be a nonzero multiple of 8");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be at least 2");
   end

   logic [CMD_W-1:0] shadow_q, next_cmd;
   logic [DW-1:0]    entry;
   logic             data_hit, push_wr, stat_wr, push_req, drop;

   assign push_wr  = bus_wr && (reg_sel_e'(bus_addr) == SEL_PUSH);
   assign stat_wr  = bus_wr && (reg_sel_e'(bus_addr) == SEL_STAT);
   assign push_req = push_wr && data_hit;
   assign drop     = push_req && fifo_full && !pop;

   txpush_merge #(.CMD_W(CMD_W), .DAT_W(DAT_W)) merge_i (
      .be       (bus_be),
      .wdata    (bus_wdata),
      .shadow   (shadow_q),
      .next_cmd (next_cmd),
      .entry    (entry),
      .data_hit (data_hit)
   );

   txpush_fifo #(.W(DW), .DEPTH(DEPTH)) fifo_i (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push_req),
      .pop   (pop),
      .din   (entry),
      .dout  (pop_data),
      .empty (fifo_empty),
      .full  (fifo_full)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shadow_q <= '0;
      end else if (push_wr) begin
         shadow_q <= next_cmd;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         overflow <= 1'b0;
      end else if (drop) begin
         overflow <= 1'b1;
      end else if (stat_wr && bus_be[0] && bus_wdata[0]) begin
         overflow <= 1'b0;
      end
   end
endmodule

// File: rtl/txpush_port_chk.sv
module txpush_port_chk #(
   parameter int unsigned CMD_W = 16,
   parameter int unsigned DAT_W = 16,
   localparam int unsigned DW = CMD_W + DAT_W,
   localparam int unsigned NB = DW / 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_wr,
   input logic          bus_addr,
   input logic [NB-1:0] bus_be,
   input logic [DW-1:0] bus_wdata,
   input logic          pop,
   input logic [DW-1:0] pop_data,
   input logic          fifo_empty,
   input logic          fifo_full,
   input logic          overflow
);
   localparam int unsigned DB = DAT_W / 8;

   logic data_only, cmd_only, clr_wr;
   assign data_only = bus_wr && !bus_addr && (|bus_be[DB-1:0]) && !(|bus_be[NB-1:DB]);
   assign cmd_only  = bus_wr && !bus_addr && !(|bus_be[DB-1:0]);
   assign clr_wr    = bus_wr && bus_addr && bus_be[0] && bus_wdata[0];

   // R8
   flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(fifo_full && fifo_empty));

   // R2
   wide_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_addr && (&bus_be) && fifo_empty)
      |=> (!fifo_empty && pop_data == $past(bus_wdata)));

   // R3
   narrow_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_only && (&bus_be[DB-1:0]) && fifo_empty)
      |=> (!fifo_empty && pop_data[DAT_W-1:0] == $past(bus_wdata[DAT_W-1:0])));

   // R5
   cmd_no_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_only && fifo_empty) |=> fifo_empty);

   // R9
   ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_addr && (|bus_be[DB-1:0]) && fifo_full && !pop) |=> overflow);

   // R9
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow && !clr_wr) |=> overflow);

   // R9
   ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr) |=> !overflow);

   // R7
   full_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_full && pop && data_only) |=> fifo_full);
endmodule

bind txpush_port txpush_port_chk #(.CMD_W(CMD_W), .DAT_W(DAT_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_be    (bus_be),
   .bus_wdata (bus_wdata),
   .pop       (pop),
   .pop_data  (pop_data),
   .fifo_empty(fifo_empty),
   .fifo_full (fifo_full),
   .overflow  (overflow)
);

// File: tb/txpush_port_test.sv
`timescale 1ns/1ps
module txpush_port_test;
   localparam int DEPTH = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_addr = 1'b0;
   logic [3:0]  bus_be = '0;
   logic [31:0] bus_wdata = '0;
   logic        pop = 1'b0;
   logic [31:0] pop_data;
   logic        fifo_empty, fifo_full, overflow;

   int n_chk = 0;
   int n_fail = 0;
   bit live = 0;
   bit done = 0;

   always #5 clk = ~clk;

   txpush_port #(.DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_be(bus_be), .bus_wdata(bus_wdata), .pop(pop),
      .pop_data(pop_data), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
      .overflow(overflow)
   );

   // behavioural reference
   logic [31:0] q[$];
   logic [15:0] m_sh;
   bit          m_ov;

   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete();
         m_sh = 16'h0;
         m_ov = 0;
      end else begin
         bit do_push;
         bit full_now;
         logic [15:0] nsh;
         logic [15:0] dat;
         full_now = (q.size() == DEPTH);
         do_push = 0;
         nsh = m_sh;
         dat = 16'h0;
         if (bus_wr && !bus_addr) begin
            if (bus_be[2]) nsh[7:0]  = bus_wdata[23:16];
            if (bus_be[3]) nsh[15:8] = bus_wdata[31:24];
            if (bus_be[0]) dat[7:0]  = bus_wdata[7:0];
            if (bus_be[1]) dat[15:8] = bus_wdata[15:8];
            do_push = bus_be[0] || bus_be[1];
            m_sh = nsh;
         end
         if (pop && q.size() > 0) void'(q.pop_front());
         if (do_push && (!full_now || pop)) q.push_back({nsh, dat});
         if (do_push && full_now && !pop) m_ov = 1;
         else if (bus_wr && bus_addr && bus_be[0] && bus_wdata[0]) m_ov = 0;
      end
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (live && rst_n) begin
         chk("R8 empty", {31'h0, fifo_empty}, {31'h0, q.size() == 0});
         chk("R8 full", {31'h0, fifo_full}, {31'h0, q.size() == DEPTH});
         chk("R9 overflow", {31'h0, overflow}, {31'h0, m_ov});
         if (q.size() > 0) chk("R7 head", pop_data, q[0]);
      end
   end

   task automatic cyc(input bit w, input bit a, input logic [3:0] be,
                      input logic [31:0] d, input bit p);
      bus_wr = w; bus_addr = a; bus_be = be; bus_wdata = d; pop = p;
      @(negedge clk);
      bus_wr = 0; bus_addr = 0; bus_be = '0; bus_wdata = '0; pop = 0;
   endtask

   task automatic head_is(string tag, logic [31:0] exp);
      chk({tag, " not empty"}, {31'h0, fifo_empty}, 32'h0);
      chk(tag, pop_data, exp);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      live = 1;
      // R1 reset state
      chk("R1 empty", {31'h0, fifo_empty}, 32'h1);
      chk("R1 full", {31'h0, fifo_full}, 32'h0);
      chk("R1 overflow", {31'h0, overflow}, 32'h0);
      cyc(1, 0, 4'b0011, 32'hFFFF_1234, 0);
      head_is("R1 zero shadow", 32'h0000_1234);
      cyc(0, 0, 4'b0000, 32'h0, 1);

      // R2 wide push
      cyc(1, 0, 4'b1111, 32'hA5A5_0001, 0);
      head_is("R2 wide", 32'hA5A5_0001);
      cyc(0, 0, 4'b0000, 32'h0, 1);

      // R3 narrow data keeps shadow
      cyc(1, 0, 4'b0011, 32'hFFFF_BEEF, 0);
      head_is("R3 narrow", 32'hA5A5_BEEF);
      cyc(0, 0, 4'b0000, 32'h0, 1);

      // R4 byte writes zero-fill
      cyc(1, 0, 4'b0010, 32'h1122_7733, 0);
      head_is("R4 upper byte", 32'hA5A5_7700);
      cyc(0, 0, 4'b0000, 32'h0, 1);
      cyc(1, 0, 4'b0001, 32'h1122_33CD, 0);
      head_is("R4 lower byte", 32'hA5A5_00CD);
      cyc(0, 0, 4'b0000, 32'h0, 1);

      // R5 command-only writes
      cyc(1, 0, 4'b1100, 32'hC3C3_9999, 0);
      chk("R5 no push", {31'h0, fifo_empty}, 32'h1);
      cyc(1, 0, 4'b1000, 32'h5A00_0000, 0);
      chk("R5 no push byte", {31'h0, fifo_empty}, 32'h1);
      cyc(1, 0, 4'b0011, 32'h0000_1111, 0);
      head_is("R5 new command", 32'h5AC3_1111);
      cyc(0, 0, 4'b0000, 32'h0, 1);

      // R6 mixed partial write
      cyc(1, 0, 4'b0111, 32'h99EE_2222, 0);
      head_is("R6 mixed", 32'h5AEE_2222);
      cyc(0, 0, 4'b0000, 32'h0, 1);

      // R10 writes that must not push
      cyc(1, 1, 4'b1111, 32'hFFFF_FFFE, 0);
      chk("R10 status no push", {31'h0, fifo_empty}, 32'h1);
      cyc(1, 0, 4'b0000, 32'h1234_5678, 0);
      chk("R10 no enables", {31'h0, fifo_empty}, 32'h1);
      cyc(1, 0, 4'b0011, 32'h0000_3333, 0);
      head_is("R10 shadow kept", 32'h5AEE_3333);
      cyc(0, 0, 4'b0000, 32'h0, 1);

      // R8 fill
      for (int k = 1; k <= DEPTH; k++) cyc(1, 0, 4'b1111, 32'h1000_0000 + k, 0);
      chk("R8 full", {31'h0, fifo_full}, 32'h1);
      // R9 overflow
      cyc(1, 0, 4'b0011, 32'h0000_DEAD, 0);
      chk("R9 set", {31'h0, overflow}, 32'h1);
      head_is("R9 dropped", 32'h1000_0001);
      cyc(1, 1, 4'b0001, 32'h0000_0000, 0);
      chk("R9 zero keeps", {31'h0, overflow}, 32'h1);
      // R7 push and pop while full
      cyc(1, 0, 4'b1111, 32'h1000_0005, 1);
      chk("R7 still full", {31'h0, fifo_full}, 32'h1);
      chk("R7 no overflow change", {31'h0, overflow}, 32'h1);
      for (int k = 2; k <= 5; k++) begin
         head_is("R7 order", 32'h1000_0000 + k);
         cyc(0, 0, 4'b0000, 32'h0, 1);
      end
      chk("R8 drained", {31'h0, fifo_empty}, 32'h1);
      cyc(0, 0, 4'b0000, 32'h0, 1);
      chk("R8 pop empty", {31'h0, fifo_empty}, 32'h1);
      cyc(1, 1, 4'b0001, 32'h0000_0001, 0);
      chk("R9 clear", {31'h0, overflow}, 32'h0);
      repeat (2) @(negedge clk);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule